// File: doc/BRIEF.md
# Fan Tachometer Period Checker

This block times the pulse train coming back from a fan's tachometer pin. The measured value is the number of system clock cycles between consecutive rising edges. Every completed period is placed in a measurement register and announced with a one-cycle event pulse. Software turns the count into a speed in revolutions per minute from the clock frequency and the fan's pulses per revolution, which is 1, 2 or 4. That conversion is not part of this block.

Each measurement is compared with a window: an expected period plus or minus a tolerance. The expected period and the tolerance come from one of two sources. The host can drive them; software usually sets the tolerance to a quarter of a fresh reading, rounded to nearest. The other source is a built-in table with one expected period per duty level, which is used after the controller itself has changed the duty. Its tolerance is a quarter of the table entry, rounded to nearest. A reading outside the window raises the error event. A missing tach signal raises the error event too, once the counter reaches its timeout limit. A settle input masks error reporting while the fan speed is still changing after a duty change.

The controller is a four-state machine:
- IDLE: the block is disabled. The counter is clear and the last result is kept.
- ARM: the block waits for the first rising edge and does not measure the partial period before it.
- MEASURE: the block counts between rising edges and publishes one result per edge.
- STALLED: the counter has stopped at the timeout limit, and the block waits for an edge.

Transitions:
- IDLE to ARM when enabled.
- ARM to MEASURE on a rising edge.
- ARM or MEASURE to STALLED when the counter reaches the limit without an edge.
- STALLED to MEASURE on a rising edge.
- MEASURE to MEASURE on each rising edge, which publishes a result.
- Any state to IDLE when the enable input is low.

Top module: `tach_period_checker`

## Requirements
- R1: After reset, `meas_value` is 0 and neither event is asserted. `meas_value` stays 0 until the first complete period after enabling has been captured. The rising edge that first arms the block publishes nothing.
- R2: The tach input passes through a synchronizer of `SYNC_STAGES` flops. Each rising edge after the first loads `meas_value` with the number of clock cycles since the previous rising edge, and `meas_evt` is high for that same cycle.
- R3: A captured value V is an error when V < E − T (the lower bound floors at 0) or when V > E + T, where E is the selected expected period and T is the selected tolerance. Both bounds are inclusive. On an error, `err_evt` pulses in the same cycle as `meas_evt`.
- R4: When `use_preset` is 0, E and T come from `host_period` and `host_tol`. When `use_preset` is 1, E is table entry `duty_level`, where entry i sits in bits [i*CNT_W +: CNT_W] of `PRESET_PERIODS`, and T = (E + 2) / 4 with integer division. In that mode the host inputs have no effect. A `duty_level` beyond the table selects the last entry.
- R5: While `settle` is high, `err_evt` stays low, both for range errors and for timeouts. Measurements and `meas_evt` continue as normal.
- R6: The counter stops at `TIMEOUT_CYC`. If that count is reached with no rising edge, `err_evt` pulses once, no `meas_evt` is produced, and `meas_value` keeps its last value. A period of exactly `TIMEOUT_CYC` cycles is measured normally.
- R7: After a stall, the first rising edge restarts timing without publishing anything or raising an error. The next edge publishes a full period.
- R8: While `enable` is low, no events occur and `meas_value` holds its value. When `enable` rises again, the first edge only arms the block, so the first published value is a complete period.
- R9: `meas_evt` never stays high for two cycles in a row, and `meas_value` changes only in a cycle where `meas_evt` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low forces IDLE |
| settle | input | 1 | High masks error events during a speed change |
| tach_in | input | 1 | Raw, asynchronous tachometer pin |
| host_period | input | CNT_W | Expected period written by the host |
| host_tol | input | CNT_W | Tolerance written by the host |
| use_preset | input | 1 | 1 selects the built-in per-level window |
| duty_level | input | LVL_W | Current duty level, used to index the table |
| meas_value | output | CNT_W | Last completed period, in clock cycles |
| meas_evt | output | 1 | One-cycle pulse for each new measurement |
| err_evt | output | 1 | One-cycle pulse for an out-of-window period or a timeout |

## Verification
The bench builds the block with `CNT_W` = 12, `TIMEOUT_CYC` = 200 and a four-entry table of 100, 60, 40 and 25 cycles for levels 0 to 3. These values keep every tach period short. A stall, the measurement of a period exactly at the limit, and a period one cycle past the limit can therefore all be reached within a few hundred cycles. The 25-cycle entry gives a tolerance of 6, which is rounded down from 6.25, so the bench can test the rounding at both window edges, at 31 and 32 cycles.

// File: rtl/tach_pkg.sv
package tach_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARM     = 2'd1,
        ST_MEASURE = 2'd2,
        ST_STALLED = 2'd3
    } tach_state_e;

    // quarter of a period, rounded to nearest (ties upward)
    function automatic int unsigned quarter_round(input int unsigned period);
        return (period + 32'd2) / 32'd4;
    endfunction

endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_raw,
    output logic rise
);

    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], tach_raw};
        end
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/tach_window.sv
module tach_window #(
    parameter int CNT_W      = 20,
    parameter int NUM_LEVELS = 4,
    parameter int LVL_W      = 2,
    parameter logic [NUM_LEVELS*CNT_W-1:0] PRESET_PERIODS = '0
) (
    input  logic             use_preset,
    input  logic [LVL_W-1:0] duty_level,
    input  logic [CNT_W-1:0] host_period,
    input  logic [CNT_W-1:0] host_tol,
    output logic [CNT_W:0]   win_lo,
    output logic [CNT_W:0]   win_hi
);

    logic [CNT_W-1:0] lvl_period [NUM_LEVELS];
    logic [CNT_W-1:0] lvl_tol    [NUM_LEVELS];
    logic [LVL_W-1:0] lvl_idx;
    logic [CNT_W-1:0] exp_sel;
    logic [CNT_W-1:0] tol_sel;

    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_level
        localparam int unsigned LVL_P = 32'(PRESET_PERIODS[i*CNT_W +: CNT_W]);
        assign lvl_period[i] = CNT_W'(LVL_P);
        assign lvl_tol[i]    = CNT_W'(tach_pkg::quarter_round(LVL_P));
    end

    always_comb begin
        if (int'(duty_level) >= NUM_LEVELS) begin
            lvl_idx = LVL_W'(NUM_LEVELS - 1);
        end else begin
            lvl_idx = duty_level;
        end
    end

    always_comb begin
        if (use_preset) begin
            exp_sel = lvl_period[lvl_idx];
            tol_sel = lvl_tol[lvl_idx];
        end else begin
            exp_sel = host_period;
            tol_sel = host_tol;
        end
    end

    assign win_hi = {1'b0, exp_sel} + {1'b0, tol_sel};
    assign win_lo = (exp_sel >= tol_sel) ? {1'b0, exp_sel - tol_sel} : '0;

endmodule

// File: rtl/tach_fsm.sv
module tach_fsm
    import tach_pkg::*;
#(
    parameter int          CNT_W       = 20,
    parameter int unsigned TIMEOUT_CYC = 1_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             settle,
    input  logic             rise,
    input  logic [CNT_W:0]   win_lo,
    input  logic [CNT_W:0]   win_hi,
    output logic [CNT_W-1:0] meas_value,
    output logic             meas_evt,
    output logic             err_evt
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

    tach_state_e      state_q;
    tach_state_e      state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             limit_hit;
    logic             out_of_win;

    assign limit_hit  = (cnt_q >= LIMIT);
    assign out_of_win = ({1'b0, cnt_q} < win_lo) || ({1'b0, cnt_q} > win_hi);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (!enable)        state_d = ST_IDLE;
                else if (rise)      state_d = ST_MEASURE;
                else if (limit_hit) state_d = ST_STALLED;
            end
            ST_MEASURE: begin
                if (!enable)        state_d = ST_IDLE;
                else if (rise)      state_d = ST_MEASURE;
                else if (limit_hit) state_d = ST_STALLED;
            end
            ST_STALLED: begin
                if (!enable)   state_d = ST_IDLE;
                else if (rise) state_d = ST_MEASURE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // counter, result register and event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            meas_value <= '0;
            meas_evt   <= 1'b0;
            err_evt    <= 1'b0;
        end else begin
            meas_evt <= 1'b0;
            err_evt  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                end
                ST_ARM, ST_MEASURE: begin
                    if (rise) begin
                        cnt_q <= CNT_W'(1);
                        if (state_q == ST_MEASURE) begin
                            meas_value <= cnt_q;
                            meas_evt   <= 1'b1;
                            err_evt    <= out_of_win & ~settle;
                        end
                    end else if (limit_hit) begin
                        err_evt <= ~settle;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_STALLED: begin
                    if (rise) cnt_q <= CNT_W'(1);
                end
                default: cnt_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/tach_period_checker.sv
module tach_period_checker #(
    parameter int          CNT_W       = 20,
    parameter int unsigned TIMEOUT_CYC = 1_000_000,
    parameter int          NUM_LEVELS  = 4,
    parameter int          SYNC_STAGES = 2,
    parameter int          LVL_W       = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
    parameter logic [NUM_LEVELS*CNT_W-1:0] PRESET_PERIODS =
        {20'd150000, 20'd250000, 20'd400000, 20'd600000}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             settle,
    input  logic             tach_in,
    input  logic [CNT_W-1:0] host_period,
    input  logic [CNT_W-1:0] host_tol,
    input  logic             use_preset,
    input  logic [LVL_W-1:0] duty_level,
    output logic [CNT_W-1:0] meas_value,
    output logic             meas_evt,
    output logic             err_evt
);

    logic           tach_rise;
    logic [CNT_W:0] win_lo;
    logic [CNT_W:0] win_hi;

    tach_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tach_raw (tach_in),
        .rise     (tach_rise)
    );

    tach_window #(
        .CNT_W          (CNT_W),
        .NUM_LEVELS     (NUM_LEVELS),
        .LVL_W          (LVL_W),
        .PRESET_PERIODS (PRESET_PERIODS)
    ) u_window (
        .use_preset  (use_preset),
        .duty_level  (duty_level),
        .host_period (host_period),
        .host_tol    (host_tol),
        .win_lo      (win_lo),
        .win_hi      (win_hi)
    );

    tach_fsm #(
        .CNT_W       (CNT_W),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .settle     (settle),
        .rise       (tach_rise),
        .win_lo     (win_lo),
        .win_hi     (win_hi),
        .meas_value (meas_value),
        .meas_evt   (meas_evt),
        .err_evt    (err_evt)
    );

endmodule

// File: rtl/tach_period_checker_sva.sv
module tach_period_checker_sva #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             settle,
    input logic [CNT_W-1:0] meas_value,
    input logic             meas_evt,
    input logic             err_evt
);

    // R1: the result register leaves reset at zero
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (meas_value == '0) && !meas_evt && !err_evt);

    // R2: a published period is at least one cycle long
    assert_nonzero_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_evt |-> (meas_value != '0));

    // R5: no error event while the settle window is active
    assert_settle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(settle) |-> !err_evt);

    // R8: two cycles after enable drops, the block is silent
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable, 2) |-> !meas_evt && !err_evt);

    // R9: measurement events are single-cycle pulses
    assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        meas_evt |=> !meas_evt);

    // R9: the result register only moves together with the event
    assert_value_with_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_value != $past(meas_value)) |-> meas_evt);

endmodule

bind tach_period_checker tach_period_checker_sva #(
    .CNT_W (CNT_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .settle     (settle),
    .meas_value (meas_value),
    .meas_evt   (meas_evt),
    .err_evt    (err_evt)
);

// File: tb/tach_period_checker_bench.sv
module tach_period_checker_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CNT_W = 12;
    localparam int TMO   = 200;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             settle = 1'b0;
    logic             tach_in;
    logic [CNT_W-1:0] host_period = '0;
    logic [CNT_W-1:0] host_tol = '0;
    logic             use_preset = 1'b0;
    logic [1:0]       duty_level = '0;
    logic [CNT_W-1:0] meas_value;
    logic             meas_evt;
    logic             err_evt;

    int n_checks = 0;
    int n_fail   = 0;
    int tach_per = 0;
    int n_meas = 0, n_err = 0, last_meas = 0, first_meas = 0;
    bit first_seen = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tach_period_checker #(
        .CNT_W          (CNT_W),
        .TIMEOUT_CYC    (TMO),
        .NUM_LEVELS     (4),
        .SYNC_STAGES    (2),
        .PRESET_PERIODS ({12'd25, 12'd40, 12'd60, 12'd100})
    ) u_tach_period_checker (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .settle      (settle),
        .tach_in     (tach_in),
        .host_period (host_period),
        .host_tol    (host_tol),
        .use_preset  (use_preset),
        .duty_level  (duty_level),
        .meas_value  (meas_value),
        .meas_evt    (meas_evt),
        .err_evt     (err_evt)
    );

    // tach generator: one rising edge every tach_per cycles, 0 = stopped
    initial begin
        int hi_len;
        int lo_len;
        tach_in = 1'b0;
        forever begin
            @(negedge clk);
            if (tach_per > 1) begin
                hi_len  = tach_per / 2;
                lo_len  = tach_per - hi_len;
                tach_in = 1'b1;
                repeat (hi_len) @(negedge clk);
                tach_in = 1'b0;
                repeat (lo_len - 1) @(negedge clk);
            end else begin
                tach_in = 1'b0;
            end
        end
    end

    // event monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (meas_evt) begin
                n_meas++;
                last_meas = int'(meas_value);
                if (!first_seen) begin
                    first_seen = 1'b1;
                    first_meas = int'(meas_value);
                end
            end
            if (err_evt) n_err++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_period(input int p);
        @(posedge clk);
        tach_per = p;
    endtask

    task automatic set_host(input int e, input int t);
        @(negedge clk);
        host_period = CNT_W'(e);
        host_tol    = CNT_W'(t);
    endtask

    task automatic flush();
        repeat (450) @(posedge clk);
    endtask

    task automatic observe(input int cycles, output int dm, output int de);
        int m0;
        int e0;
        @(posedge clk);
        m0 = n_meas;
        e0 = n_err;
        first_seen = 1'b0;
        repeat (cycles) @(posedge clk);
        dm = n_meas - m0;
        de = n_err - e0;
    endtask

    // steady tach at period p; expect_err: every capture should flag
    task automatic run_case(input int p, input bit expect_err, input string req);
        int dm;
        int de;
        set_period(p);
        flush();
        observe(6 * p, dm, de);
        check(last_meas == p, req, "measured period", last_meas, p);
        check(dm >= 5, req, "measurement count", dm, 5);
        check(de == (expect_err ? dm : 0), req, "error count", de, expect_err ? dm : 0);
    endtask

    task automatic t_reset_and_first();
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(meas_value == '0, "R1", "value after reset", int'(meas_value), 0);
        check(!meas_evt && !err_evt, "R1", "events after reset",
              int'({meas_evt, err_evt}), 0);
        set_host(50, 13);
        enable = 1'b1;
        set_period(50);
        repeat (40) @(posedge clk);
        check(n_meas == 0, "R1", "events before full period", n_meas, 0);
        check(meas_value == '0, "R1", "value before full period", int'(meas_value), 0);
        repeat (60) @(posedge clk);
        check(n_meas >= 1 && first_meas == 50, "R2", "first captured period", first_meas, 50);
        check(n_err == 0, "R1", "no error from arming edge", n_err, 0);
    endtask

    task automatic t_host_window();
        run_case(50, 1'b0, "R2");
        run_case(70, 1'b1, "R3");
        set_host(50, 10);
        run_case(60, 1'b0, "R3");
        run_case(40, 1'b0, "R3");
        run_case(61, 1'b1, "R3");
        run_case(39, 1'b1, "R3");
    endtask

    task automatic t_preset();
        set_host(50, 0);
        @(negedge clk);
        use_preset = 1'b1;
        duty_level = 2'd2;
        run_case(40, 1'b0, "R4");
        @(negedge clk);
        duty_level = 2'd0;
        run_case(40, 1'b1, "R4");
        @(negedge clk);
        duty_level = 2'd3;
        run_case(31, 1'b0, "R4");
        run_case(32, 1'b1, "R4");
        @(negedge clk);
        use_preset = 1'b0;
    endtask

    task automatic t_settle();
        set_host(50, 13);
        @(negedge clk);
        settle = 1'b1;
        run_case(70, 1'b0, "R5");
        @(negedge clk);
        settle = 1'b0;
        run_case(70, 1'b1, "R5");
    endtask

    task automatic t_timeout();
        int dm;
        int de;
        run_case(50, 1'b0, "R6");
        set_period(0);
        observe(450, dm, de);
        check(de == 1, "R6", "single timeout error", de, 1);
        check(meas_value == 12'd50, "R6", "value held on stall", int'(meas_value), 50);
        set_period(50);
        observe(300, dm, de);
        check(de == 0, "R7", "no error on restart", de, 0);
        check(first_meas == 50, "R7", "first value after stall", first_meas, 50);
        check(dm >= 4, "R7", "measurements resume", dm, 4);
        @(negedge clk);
        settle = 1'b1;
        set_period(0);
        observe(450, dm, de);
        check(de == 0, "R5", "timeout masked by settle", de, 0);
        @(negedge clk);
        settle = 1'b0;
        set_host(200, 50);
        run_case(200, 1'b0, "R6");
        set_period(201);
        flush();
        observe(5 * 201, dm, de);
        check(dm == 0, "R6", "no capture beyond limit", dm, 0);
        check(de >= 4, "R6", "error per overlong period", de, 4);
    endtask

    task automatic t_enable();
        int dm;
        int de;
        set_host(50, 13);
        run_case(50, 1'b0, "R8");
        @(negedge clk);
        enable = 1'b0;
        repeat (5) @(posedge clk);
        observe(300, dm, de);
        check(dm == 0 && de == 0, "R8", "events while disabled", dm + de, 0);
        check(meas_value == 12'd50, "R8", "value held while disabled", int'(meas_value), 50);
        @(negedge clk);
        enable = 1'b1;
        observe(300, dm, de);
        check(first_meas == 50, "R8", "first value after re-enable", first_meas, 50);
        check(de == 0, "R8", "no error after re-enable", de, 0);
    endtask

    initial begin
        t_reset_and_first();
        t_host_window();
        t_preset();
        t_settle();
        t_timeout();
        t_enable();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule